// File: doc/BRIEF.md
# Zero-Skipping Sparse Matrix-Vector Accumulator

This block adds a matrix-vector product into a stored result vector. It leaves out every matrix column that a per-column marker tags as empty. A host fills four internal memories through one shared word port while the block is idle: the input vector, the result vector, the row-major weight matrix and the column markers. It then pulses `start` and waits for `done`.

A run has two phases. First a compaction pass reads one marker per cycle. It appends the number of every column that is not tagged empty to an internal list and counts the entries. Then a compute pass walks only the listed columns. For each one it sweeps every row and issues one multiply-accumulate per cycle into the result vector. A tagged column therefore costs one cycle of scanning and nothing in the compute pass.

The result vector is not cleared by `start`, so a second run adds on top of the first. After `done` the host reads the results through the same port.

Top module: `zs_spmv_top`

## Requirements
- R1: After reset, `done` and `busy` are low.
- R2: While idle, a host write stores `host_wdata` at `host_addr` in the memory chosen by `host_sel`. The encodings are 0 = input vector, 1 = result vector, 2 = weights, 3 = column markers. A read presents `host_sel`/`host_addr` and returns the word on `host_rdata` one cycle later.
- R3: A column whose 32-bit marker equals exactly 1 adds nothing to any result word. Every other marker value, including 0, 2, all-ones and 0x80000001, lets the column be processed.
- R4: For every processed column j and every row i, result[i] gains weight[i*COLS + j] * input[i]. Weight address i*COLS + j is row-major. The product keeps its low 32 bits and the sum wraps modulo 2^32.
- R5: With cnt > 0 processed columns, where the cycle after the clock edge that samples `start` is cycle 1, `done` is high in cycle COLS + 5 + ROWS*cnt. That is one multiply-accumulate per cycle.
- R6: With no processed column, `done` is high in cycle COLS + 2, and all result words keep their values.
- R7: `done` is high for exactly one cycle. `busy` is high from cycle 1 through the `done` cycle and low afterwards.
- R8: `start` asserted while a run is in progress is ignored. The run's timing and results are unchanged.
- R9: Host writes while `busy` is high are ignored. A write aimed at a result word during a run leaves that word with the value the run produces.
- R10: `start` does not clear the result vector, so a second run with the same memories adds the same contribution a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| done | output | 1 | One-cycle pulse when the run is complete |
| busy | output | 1 | High while a run is in progress |
| host_we | input | 1 | Host write enable (idle only) |
| host_sel | input | 2 | Memory select: 0 input, 1 result, 2 weights, 3 markers |
| host_addr | input | $clog2(ROWS*COLS) | Word address inside the selected memory |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data, one cycle after the address |

## Verification
The bench aims at marker patterns that exercise the list edges: every column processed, none processed, only the first or only the last column, and alternating columns with odd marker values such as all-ones. A design that tested only the low marker bit, or dropped the final scanned flag, would show wrong sums or a wrong cycle count. Exact cycle counts expose a design that spends compute cycles on skipped columns or stalls between columns. Back-to-back columns hitting the same rows expose a read-after-write hazard, because the earlier column's contribution would be lost. Starts and host writes injected mid-run, and a second run without reloading, catch restarts, host writes that slip through, and results cleared on start.

// File: rtl/zs_pkg.sv
package zs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_WRAP,
        ST_LOAD,
        ST_RUN,
        ST_DRAIN,
        ST_FIN
    } zs_state_e;

    localparam logic [1:0] SEL_IN   = 2'd0;
    localparam logic [1:0] SEL_OUT  = 2'd1;
    localparam logic [1:0] SEL_WGT  = 2'd2;
    localparam logic [1:0] SEL_FLAG = 2'd3;
endpackage

// File: rtl/zs_ram.sv
module zs_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    // read returns the word held before a same-edge write
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/zs_ctrl.sv
module zs_ctrl
    import zs_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 32,
    localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int CW  = $clog2(COLS + 1),
    localparam int WAW = $clog2(ROWS * COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DW-1:0]  flag_rdata,
    input  logic [CAW-1:0] idx_rdata,
    output logic           busy,
    output logic           done,
    output logic [CAW-1:0] flag_raddr,
    output logic           idx_we,
    output logic [CAW-1:0] idx_waddr,
    output logic [CAW-1:0] idx_wdata,
    output logic [CAW-1:0] idx_raddr,
    output logic           iss_vld,
    output logic [RAW-1:0] iss_row,
    output logic [WAW-1:0] w_raddr
);
    typedef struct packed {
        zs_state_e      st;
        logic [CAW-1:0] scan;
        logic           fvld;
        logic [CAW-1:0] fcol;
        logic [CW-1:0]  cnt;
        logic [CAW-1:0] k;
        logic [RAW-1:0] row;
        logic           drain;
    } ctrl_s;

    ctrl_s s_q, s_d;
    logic  last_col;

    always_comb begin
        s_d      = s_q;
        // pending marker from the previous scan cycle: append unless it is exactly 1
        idx_we   = (s_q.st == ST_SCAN || s_q.st == ST_WRAP) && s_q.fvld
                   && (flag_rdata != DW'(1));
        if (idx_we) s_d.cnt = s_q.cnt + CW'(1);
        last_col = ((CW'(s_q.k) + CW'(1)) == s_q.cnt);

        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_SCAN;
                    s_d.scan = '0;
                    s_d.fvld = 1'b0;
                    s_d.cnt  = '0;
                    s_d.k    = '0;
                    s_d.row  = '0;
                end
            end
            ST_SCAN: begin
                s_d.fvld = 1'b1;
                s_d.fcol = s_q.scan;
                if (s_q.scan == CAW'(COLS - 1)) s_d.st = ST_WRAP;
                else                             s_d.scan = s_q.scan + CAW'(1);
            end
            ST_WRAP: begin
                s_d.fvld = 1'b0;
                s_d.st   = (s_d.cnt == '0) ? ST_FIN : ST_LOAD;
            end
            ST_LOAD: begin
                s_d.st  = ST_RUN;
                s_d.k   = '0;
                s_d.row = '0;
            end
            ST_RUN: begin
                if (s_q.row == RAW'(ROWS - 1)) begin
                    s_d.row = '0;
                    if (last_col) begin
                        s_d.st    = ST_DRAIN;
                        s_d.drain = 1'b0;
                    end else begin
                        s_d.k = s_q.k + CAW'(1);
                    end
                end else begin
                    s_d.row = s_q.row + RAW'(1);
                end
            end
            ST_DRAIN: begin
                if (s_q.drain) s_d.st = ST_FIN;
                else           s_d.drain = 1'b1;
            end
            ST_FIN:  s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign done       = (s_q.st == ST_FIN);
    assign flag_raddr = s_q.scan;
    assign idx_waddr  = s_q.cnt[CAW-1:0];
    assign idx_wdata  = s_q.fcol;
    // list is read one cycle ahead so a new column costs no bubble
    assign idx_raddr  = s_d.k;
    assign iss_vld    = (s_q.st == ST_RUN);
    assign iss_row    = s_q.row;
    assign w_raddr    = WAW'(s_q.row) * WAW'(COLS) + WAW'(idx_rdata);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.cnt == '0) |-> $past(s_q.st) == ST_WRAP); // R6
    AST_RUN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> (s_q.cnt != '0)); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && start) |=> (s_q.st == ST_RUN || s_q.st == ST_DRAIN)); // R8
endmodule

// File: rtl/zs_mac.sv
module zs_mac #(
    parameter int ROWS = 16,
    parameter int DW   = 32,
    localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_vld,
    input  logic [RAW-1:0] iss_row,
    input  logic [DW-1:0]  w_rd,
    input  logic [DW-1:0]  x_rd,
    input  logic [DW-1:0]  y_rd,
    output logic           wr_en,
    output logic [RAW-1:0] wr_row,
    output logic [DW-1:0]  wr_data
);
    typedef struct packed {
        logic           v1;
        logic [RAW-1:0] r1;
        logic           v2;
        logic [RAW-1:0] r2;
        logic [DW-1:0]  sum2;
    } mac_s;

    mac_s          s_q, s_d;
    logic [DW-1:0] prod;

    always_comb begin
        s_d    = s_q;
        prod   = w_rd * x_rd;  // low DW bits kept
        s_d.v1 = iss_vld;
        s_d.r1 = iss_row;
        s_d.v2 = s_q.v1;
        s_d.r2 = s_q.r1;
        if (s_q.v1) s_d.sum2 = y_rd + prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_en   = s_q.v2;
    assign wr_row  = s_q.r2;
    assign wr_data = s_q.sum2;

    // a row read must never overtake a write still in flight to that row
    AST_NO_RAW_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> !((s_q.v1 && s_q.r1 == iss_row) || (s_q.v2 && s_q.r2 == iss_row))); // R4
endmodule

// File: rtl/zs_spmv_top.sv
module zs_spmv_top
    import zs_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 32,
    localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CAW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int WAW = $clog2(ROWS * COLS),
    localparam int HAW = WAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           done,
    output logic           busy,
    input  logic           host_we,
    input  logic [1:0]     host_sel,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    output logic [DW-1:0]  host_rdata
);
    // pipeline depth of two needs at least three rows between revisits
    if (ROWS < 3) begin : g_rows_check
        $error("zs_spmv_top needs ROWS >= 3");
    end

    logic           idle;
    logic [DW-1:0]  in_rd, out_rd, w_rd, flag_rd;
    logic [CAW-1:0] idx_rd, flag_raddr, idx_waddr, idx_wdata, idx_raddr;
    logic           idx_we, iss_vld, mac_we;
    logic [RAW-1:0] iss_row, mac_row;
    logic [WAW-1:0] w_raddr;
    logic [DW-1:0]  mac_data;
    logic [1:0]     rsel_q;

    logic           in_we, out_we, w_we, f_we;
    logic [RAW-1:0] in_ra, out_ra, out_wa;
    logic [WAW-1:0] w_ra;
    logic [CAW-1:0] f_ra;
    logic [DW-1:0]  out_wd;

    assign idle   = !busy;
    assign in_we  = idle && host_we && (host_sel == SEL_IN);
    assign w_we   = idle && host_we && (host_sel == SEL_WGT);
    assign f_we   = idle && host_we && (host_sel == SEL_FLAG);
    assign out_we = idle ? (host_we && (host_sel == SEL_OUT)) : mac_we;
    assign out_wa = idle ? host_addr[RAW-1:0] : mac_row;
    assign out_wd = idle ? host_wdata : mac_data;
    assign in_ra  = idle ? host_addr[RAW-1:0] : iss_row;
    assign out_ra = idle ? host_addr[RAW-1:0] : iss_row;
    assign w_ra   = idle ? host_addr[WAW-1:0] : w_raddr;
    assign f_ra   = idle ? host_addr[CAW-1:0] : flag_raddr;

    zs_ram #(.DEPTH(ROWS), .W(DW)) u_in (
        .clk(clk), .we(in_we), .waddr(host_addr[RAW-1:0]), .wdata(host_wdata),
        .raddr(in_ra), .rdata(in_rd));

    zs_ram #(.DEPTH(ROWS), .W(DW)) u_out (
        .clk(clk), .we(out_we), .waddr(out_wa), .wdata(out_wd),
        .raddr(out_ra), .rdata(out_rd));

    zs_ram #(.DEPTH(ROWS * COLS), .W(DW)) u_wgt (
        .clk(clk), .we(w_we), .waddr(host_addr[WAW-1:0]), .wdata(host_wdata),
        .raddr(w_ra), .rdata(w_rd));

    zs_ram #(.DEPTH(COLS), .W(DW)) u_flag (
        .clk(clk), .we(f_we), .waddr(host_addr[CAW-1:0]), .wdata(host_wdata),
        .raddr(f_ra), .rdata(flag_rd));

    zs_ram #(.DEPTH(COLS), .W(CAW)) u_idx (
        .clk(clk), .we(idx_we), .waddr(idx_waddr), .wdata(idx_wdata),
        .raddr(idx_raddr), .rdata(idx_rd));

    zs_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .flag_rdata(flag_rd),
        .idx_rdata(idx_rd), .busy(busy), .done(done), .flag_raddr(flag_raddr),
        .idx_we(idx_we), .idx_waddr(idx_waddr), .idx_wdata(idx_wdata),
        .idx_raddr(idx_raddr), .iss_vld(iss_vld), .iss_row(iss_row),
        .w_raddr(w_raddr));

    zs_mac #(.ROWS(ROWS), .DW(DW)) u_mac (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_row(iss_row),
        .w_rd(w_rd), .x_rd(in_rd), .y_rd(out_rd),
        .wr_en(mac_we), .wr_row(mac_row), .wr_data(mac_data));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsel_q <= '0;
        else        rsel_q <= host_sel;
    end

    always_comb begin
        unique case (rsel_q)
            SEL_IN:  host_rdata = in_rd;
            SEL_OUT: host_rdata = out_rd;
            SEL_WGT: host_rdata = w_rd;
            default: host_rdata = flag_rd;
        endcase
    end

    AST_ENGINE_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mac_we |-> busy); // R9
    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !iss_vld); // R8
endmodule

// File: tb/tb_zs_spmv_top.sv
module tb_zs_spmv_top;
    localparam int ROWS = 16;
    localparam int COLS = 16;
    localparam int DW   = 32;
    localparam int HAW  = $clog2(ROWS * COLS);

    // each entry: [31:16] skip mask (bit set -> marker 1), [15:0] data seed
    localparam logic [31:0] VEC [7] = '{
        {16'h0000, 16'd1},   // all columns processed
        {16'hFFFF, 16'd2},   // none processed
        {16'hAAAA, 16'd3},   // alternating
        {16'h7FFE, 16'd4},   // first and last only
        {16'hFFFE, 16'd5},   // column 0 only
        {16'h7FFF, 16'd6},   // last column only
        {16'h0F0F, 16'd7}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           done, busy;
    logic           host_we = 1'b0;
    logic [1:0]     host_sel = '0;
    logic [HAW-1:0] host_addr = '0;
    logic [DW-1:0]  host_wdata = '0;
    logic [DW-1:0]  host_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [DW-1:0] w_m [ROWS*COLS];
    logic [DW-1:0] x_m [ROWS];
    logic [DW-1:0] y_m [ROWS];
    logic [DW-1:0] f_m [COLS];
    int            cnt_m;

    always #5 clk = ~clk;

    zs_spmv_top #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .busy(busy),
        .host_we(host_we), .host_sel(host_sel), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input int a, input int b);
        logic [31:0] h;
        h = 32'(a) * 32'h9E3779B1 + 32'(b) * 32'h85EBCA6B;
        h = h ^ (h >> 15);
        h = h * 32'h2C1B3C6D;
        h = h ^ (h >> 12);
        return h;
    endfunction

    task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_addr = HAW'(addr); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input int addr, output logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_addr = HAW'(addr);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic load(input logic [15:0] mask, input int seed);
        logic [31:0] nz [4];
        nz = '{32'h0, 32'h2, 32'hFFFF_FFFF, 32'h8000_0001};
        cnt_m = 0;
        for (int j = 0; j < COLS; j++) begin
            f_m[j] = mask[j] ? 32'h1 : nz[j % 4];
            if (!mask[j]) cnt_m++;
            wr(2'd3, j, f_m[j]);
        end
        for (int i = 0; i < ROWS; i++) begin
            x_m[i] = mix(seed, 50 + i);
            y_m[i] = mix(seed, 90 + i);
            wr(2'd0, i, x_m[i]);
            wr(2'd1, i, y_m[i]);
        end
        for (int a = 0; a < ROWS * COLS; a++) begin
            w_m[a] = mix(seed, 1000 + a);
            wr(2'd2, a, w_m[a]);
        end
    endtask

    // advance the model result vector by one run (R3, R4)
    task automatic model_run();
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                if (f_m[j] != 32'h1) y_m[i] = y_m[i] + w_m[i*COLS + j] * x_m[i];
    endtask

    task automatic run_job(input bit poke, output int cyc);
        bit busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && (cyc == 3 || cyc == COLS + 6)) begin
                start = 1'b1; host_we = 1'b1; host_sel = 2'd1;
                host_addr = '0; host_wdata = 32'hDEAD_BEEF;
            end else begin
                start = 1'b0; host_we = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; host_we = 1'b0;
        check(busy_ok && busy, "R7 busy high through run", 32'(busy_ok), 32'h1);
        @(negedge clk);
        check(!done, "R7 done one cycle", 32'(done), 32'h0);
        check(!busy, "R7 busy low after done", 32'(busy), 32'h0);
    endtask

    task automatic check_outputs(input string req);
        logic [31:0] d;
        for (int i = 0; i < ROWS; i++) begin
            rd(2'd1, i, d);
            check(d == y_m[i], req, d, y_m[i]);
        end
    endtask

    function automatic int exp_lat(input int c);
        return (c == 0) ? COLS + 2 : COLS + 5 + ROWS * c;
    endfunction

    initial begin
        int          cyc;
        logic [31:0] d;

        repeat (3) @(negedge clk);
        check(!done && !busy, "R1 reset outputs", {30'b0, done, busy}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy, "R1 after release", {30'b0, done, busy}, 32'h0);

        // R2: one word in each memory, distinct values, then read back
        wr(2'd0, 3, 32'h1111_0003);
        wr(2'd1, 5, 32'h2222_0005);
        wr(2'd2, 200, 32'h3333_00C8);
        wr(2'd3, 7, 32'h4444_0007);
        rd(2'd0, 3, d);   check(d == 32'h1111_0003, "R2 input readback", d, 32'h1111_0003);
        rd(2'd1, 5, d);   check(d == 32'h2222_0005, "R2 result readback", d, 32'h2222_0005);
        rd(2'd2, 200, d); check(d == 32'h3333_00C8, "R2 weight readback", d, 32'h3333_00C8);
        rd(2'd3, 7, d);   check(d == 32'h4444_0007, "R2 marker readback", d, 32'h4444_0007);

        // vector table: R3, R4, R5, R6
        foreach (VEC[v]) begin
            load(VEC[v][31:16], int'(VEC[v][15:0]));
            run_job(1'b0, cyc);
            check(cyc == exp_lat(cnt_m), (cnt_m == 0) ? "R6 latency" : "R5 latency",
                  32'(cyc), 32'(exp_lat(cnt_m)));
            model_run();
            check_outputs((cnt_m == 0) ? "R6 result unchanged" : "R3 R4 result");
        end

        // R8, R9: start and result writes injected during a run
        load(16'h00F0, 9);
        run_job(1'b1, cyc);
        check(cyc == exp_lat(cnt_m), "R8 latency with mid-run start", 32'(cyc),
              32'(exp_lat(cnt_m)));
        model_run();
        check_outputs("R9 result after mid-run write");

        // R10: rerun without reloading accumulates again
        run_job(1'b0, cyc);
        check(cyc == exp_lat(cnt_m), "R10 rerun latency", 32'(cyc), 32'(exp_lat(cnt_m)));
        model_run();
        check_outputs("R10 accumulate on rerun");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule